// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This controller is the bookkeeping core of a pipeline that issues instructions in program order but lets them execute and finish out of order across a small fixed set of functional units. It accepts decoded instructions (target unit, operation, destination and two source registers) through a valid/ready handshake. Every instruction then passes four gates: issue, operand read, execution and write-back. The controller raises a one-cycle operand-read grant toward a unit once its sources are safe to read. It watches a completion pulse from each unit, and it raises a write-back grant once the result can be written without destroying a value that some other unit still has to read.

Hazards are handled only by stalling. Nothing is forwarded and nothing is renamed. A unit that waits on a source is released by the write-back of that source's producer, and it reads the register file in the cycle after that write-back. The datapaths, the register file and the unit pipelines are outside the block. For each unit the block keeps a status record: state, operation, destination, two sources, two producer tags and two ready flags. It also keeps a table that records which unit will next write each register.

Top module: `sb_scoreboard`

## Requirements
- R1: An instruction issues exactly in a cycle where `in_valid` and `in_ready` are both high. A presented instruction that is refused is held and retried, and no later instruction can issue ahead of it. The unit named by `in_fu` (unit k is bit k of every per-unit vector) becomes busy from the next cycle.
- R2: `in_ready` is low while the unit named by `in_fu` is busy, unless that unit receives its write-back grant in the same cycle.
- R3: `in_ready` is low while the register `in_dst` has a pending producer, unless that producer receives its write-back grant in the same cycle.
- R4: `rd_grant[k]` is raised only when neither source of unit k has an outstanding producer. The earliest it is raised is the cycle after issue.
- R5: `wb_grant[k]` is held low while any other unit has issued, has not yet read its operands, and has a source register equal to unit k's destination with that source already marked ready.
- R6: `rd_grant[k]` lasts exactly one cycle. After that cycle unit k no longer holds back any other unit's write-back.
- R7: A pulse on `ex_done[k]` while unit k is executing makes `wb_grant[k]` eligible from the next cycle. A pulse while unit k is not executing has no effect.
- R8: A write-back grant frees the unit and the register-table entry of its destination. An issue in the same cycle may use the freed unit or the freed register, and the new issue wins the table entry. A later instruction to that register therefore stalls until the new producer writes back.
- R9: A unit that is waiting on a producer sees that source become ready when the producer is granted write-back. It then receives `rd_grant` in the next cycle if its other source is ready. This also holds for an instruction that issues in the same cycle as the producer's write-back.
- R10: After reset every unit is idle, the register table is empty, no grant is raised and `in_ready` is high.
- R11: `fu_op[k*OP_W +: OP_W]` presents the operation issued to unit k while unit k holds that instruction, including the cycle of its operand-read grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_ready | output | 1 | The presented instruction may issue this cycle |
| in_fu | input | $clog2(NUM_FU) | Functional unit required |
| in_op | input | OP_W | Operation code for the unit |
| in_dst | input | $clog2(NUM_REGS) | Destination register |
| in_src1 | input | $clog2(NUM_REGS) | First source register |
| in_src2 | input | $clog2(NUM_REGS) | Second source register |
| ex_done | input | NUM_FU | Per-unit pulse: execution finished |
| rd_grant | output | NUM_FU | Per-unit pulse: read operands now |
| fu_op | output | NUM_FU*OP_W | Operation held by each unit |
| wb_grant | output | NUM_FU | Per-unit pulse: write result now |

## Verification
The bench builds the controller with its defaults of four units, eight registers and a four-bit operation code. Four units are enough to have a producer, a waiting consumer, a unit blocked on write-back and a fourth, stalled instruction in flight together. That brings within reach a write-back held by a reader that is itself waiting on another producer, and an issue that reuses a unit and a register in the same cycle they are freed. Eight registers leave room to keep independent instructions apart from the chains under test.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // Life cycle of one functional-unit record
    typedef enum logic [1:0] {
        SLOT_IDLE    = 2'd0,
        SLOT_WAIT_RD = 2'd1,
        SLOT_EXEC    = 2'd2,
        SLOT_WAIT_WB = 2'd3
    } slot_state_e;

endpackage

// File: rtl/sb_fu_slot.sv
module sb_fu_slot
    import sb_pkg::*;
#(
    parameter int NUM_FU = 4,
    parameter int OP_W   = 4,
    parameter int REG_W  = 3,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_en,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [REG_W-1:0]  iss_dst,
    input  logic [REG_W-1:0]  iss_src1,
    input  logic [REG_W-1:0]  iss_src2,
    input  logic [TAG_W-1:0]  iss_q1,
    input  logic [TAG_W-1:0]  iss_q2,
    input  logic [NUM_FU-1:0] wb_bcast,
    input  logic              ex_done_i,
    input  logic              wb_grant_i,
    output logic              busy_o,
    output logic              wb_req_o,
    output logic              rd_grant_o,
    output logic [OP_W-1:0]   op_o,
    output logic [REG_W-1:0]  dst_o,
    output logic [REG_W-1:0]  src1_o,
    output logic [REG_W-1:0]  src2_o,
    output logic              rdy1_o,
    output logic              rdy2_o
);

    typedef struct packed {
        slot_state_e      state;
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src1;
        logic [REG_W-1:0] src2;
        logic [TAG_W-1:0] q1;
        logic [TAG_W-1:0] q2;
        logic             r1;
        logic             r2;
    } rec_t;

    rec_t rec_d, rec_q;

    // True when the unit named by tag is writing back this cycle
    function automatic logic tag_retires(input logic [TAG_W-1:0] tag,
                                         input logic [NUM_FU-1:0] bcast);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < NUM_FU; k++) begin
            if (tag == TAG_W'(k + 1) && bcast[k]) hit = 1'b1;
        end
        return hit;
    endfunction

    assign rd_grant_o = (rec_q.state == SLOT_WAIT_RD) && rec_q.r1 && rec_q.r2;

    always_comb begin
        rec_d = rec_q;
        // Producer broadcast releases waiting sources
        if (rec_q.state == SLOT_WAIT_RD) begin
            if (rec_q.q1 != '0 && tag_retires(rec_q.q1, wb_bcast)) begin
                rec_d.r1 = 1'b1;
                rec_d.q1 = '0;
            end
            if (rec_q.q2 != '0 && tag_retires(rec_q.q2, wb_bcast)) begin
                rec_d.r2 = 1'b1;
                rec_d.q2 = '0;
            end
        end
        // Operand read: drop ready flags so no write-back is held any more
        if (rd_grant_o) begin
            rec_d.state = SLOT_EXEC;
            rec_d.r1    = 1'b0;
            rec_d.r2    = 1'b0;
        end
        if (rec_q.state == SLOT_EXEC && ex_done_i) begin
            rec_d.state = SLOT_WAIT_WB;
        end
        if (rec_q.state == SLOT_WAIT_WB && wb_grant_i) begin
            rec_d = '0;
        end
        // A new issue overrides a write-back in the same cycle
        if (issue_en) begin
            rec_d.state = SLOT_WAIT_RD;
            rec_d.op    = iss_op;
            rec_d.dst   = iss_dst;
            rec_d.src1  = iss_src1;
            rec_d.src2  = iss_src2;
            rec_d.q1    = iss_q1;
            rec_d.q2    = iss_q2;
            rec_d.r1    = (iss_q1 == '0);
            rec_d.r2    = (iss_q2 == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign busy_o   = (rec_q.state != SLOT_IDLE);
    assign wb_req_o = (rec_q.state == SLOT_WAIT_WB);
    assign op_o     = rec_q.op;
    assign dst_o    = rec_q.dst;
    assign src1_o   = rec_q.src1;
    assign src2_o   = rec_q.src2;
    assign rdy1_o   = rec_q.r1;
    assign rdy2_o   = rec_q.r2;

    // R4: a source with a named producer is never marked ready
    p_raw_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_q.state == SLOT_WAIT_RD && (rec_q.q1 != '0 || rec_q.q2 != '0)) |-> !rd_grant_o);

    // R6: operand read moves to execution with both flags dropped, one pulse only
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant_o |=> (rec_q.state == SLOT_EXEC && !rec_q.r1 && !rec_q.r2 && !rd_grant_o));

    // R7: write-back granted only after completion was seen
    p_wb_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_grant_i |-> rec_q.state == SLOT_WAIT_WB);

    // R1: an issued instruction always starts by waiting for operands
    p_issue_enters_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |=> rec_q.state == SLOT_WAIT_RD);

endmodule

// File: rtl/sb_result_table.sv
module sb_result_table #(
    parameter int NUM_FU   = 4,
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 3,
    parameter int TAG_W    = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             set_en,
    input  logic [REG_W-1:0]                 set_reg,
    input  logic [TAG_W-1:0]                 set_tag,
    input  logic [NUM_FU-1:0]                clr_en,
    input  logic [NUM_FU-1:0][REG_W-1:0]     clr_reg,
    output logic [NUM_REGS-1:0][TAG_W-1:0]   tbl_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0][TAG_W-1:0] tag;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [NUM_REGS-1:0] clr_hit;

    always_comb begin
        tbl_d   = tbl_q;
        clr_hit = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            for (int u = 0; u < NUM_FU; u++) begin
                if (clr_en[u] && clr_reg[u] == REG_W'(r) &&
                    tbl_q.tag[r] == TAG_W'(u + 1)) begin
                    clr_hit[r]   = 1'b1;
                    tbl_d.tag[r] = '0;
                end
            end
            // Issue has priority over a clear of the same entry
            if (set_en && set_reg == REG_W'(r)) begin
                tbl_d.tag[r] = set_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign tbl_o = tbl_q.tag;

    // R3: a register is claimed only when empty or released this cycle
    p_single_writer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> (tbl_q.tag[set_reg] == '0 || clr_hit[set_reg]));

    // R8: a unit writing back always owns its destination entry
    generate
        for (genvar u = 0; u < NUM_FU; u++) begin : g_own
            p_owner_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
                clr_en[u] |-> tbl_q.tag[clr_reg[u]] == TAG_W'(u + 1));
        end
    endgenerate

endmodule

// File: rtl/sb_issue_gate.sv
module sb_issue_gate #(
    parameter int NUM_FU   = 4,
    parameter int NUM_REGS = 8,
    parameter int FU_W     = 2,
    parameter int REG_W    = 3,
    parameter int TAG_W    = 3
) (
    input  logic                           in_valid,
    input  logic [FU_W-1:0]                in_fu,
    input  logic [REG_W-1:0]               in_dst,
    input  logic [REG_W-1:0]               in_src1,
    input  logic [REG_W-1:0]               in_src2,
    input  logic [NUM_FU-1:0]              busy,
    input  logic [NUM_FU-1:0]              wb_grant,
    input  logic [NUM_REGS-1:0][TAG_W-1:0] tbl,
    output logic                           in_ready,
    output logic [NUM_FU-1:0]              issue_en,
    output logic [TAG_W-1:0]               q1,
    output logic [TAG_W-1:0]               q2,
    output logic [TAG_W-1:0]               set_tag
);

    function automatic logic retiring(input logic [TAG_W-1:0] tag,
                                      input logic [NUM_FU-1:0] grant);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < NUM_FU; k++) begin
            if (tag == TAG_W'(k + 1) && grant[k]) hit = 1'b1;
        end
        return hit;
    endfunction

    logic [TAG_W-1:0] dst_owner, p1, p2;
    logic             unit_free, dst_free, fire;

    always_comb begin
        dst_owner = tbl[in_dst];
        unit_free = !busy[in_fu] || wb_grant[in_fu];
        dst_free  = (dst_owner == '0) || retiring(dst_owner, wb_grant);
        in_ready  = unit_free && dst_free;
        fire      = in_valid && in_ready;
        for (int k = 0; k < NUM_FU; k++) begin
            issue_en[k] = fire && (in_fu == FU_W'(k));
        end
        // A producer retiring this cycle counts as already written
        p1 = tbl[in_src1];
        p2 = tbl[in_src2];
        q1 = retiring(p1, wb_grant) ? '0 : p1;
        q2 = retiring(p2, wb_grant) ? '0 : p2;
        set_tag = TAG_W'(in_fu) + TAG_W'(1);
    end

endmodule

// File: rtl/sb_hazard_net.sv
module sb_hazard_net #(
    parameter int NUM_FU = 4,
    parameter int REG_W  = 3
) (
    input  logic [NUM_FU-1:0]            wb_req,
    input  logic [NUM_FU-1:0][REG_W-1:0] dst,
    input  logic [NUM_FU-1:0][REG_W-1:0] src1,
    input  logic [NUM_FU-1:0][REG_W-1:0] src2,
    input  logic [NUM_FU-1:0]            rdy1,
    input  logic [NUM_FU-1:0]            rdy2,
    output logic [NUM_FU-1:0]            wb_grant
);

    logic [NUM_FU-1:0] war_block;

    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            war_block[u] = 1'b0;
            for (int f = 0; f < NUM_FU; f++) begin
                if (f != u) begin
                    if ((rdy1[f] && src1[f] == dst[u]) ||
                        (rdy2[f] && src2[f] == dst[u])) begin
                        war_block[u] = 1'b1;
                    end
                end
            end
            wb_grant[u] = wb_req[u] && !war_block[u];
        end
    end

endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard #(
    parameter int NUM_FU   = 4,
    parameter int NUM_REGS = 8,
    parameter int OP_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [$clog2(NUM_FU)-1:0]   in_fu,
    input  logic [OP_W-1:0]             in_op,
    input  logic [$clog2(NUM_REGS)-1:0] in_dst,
    input  logic [$clog2(NUM_REGS)-1:0] in_src1,
    input  logic [$clog2(NUM_REGS)-1:0] in_src2,
    input  logic [NUM_FU-1:0]           ex_done,
    output logic [NUM_FU-1:0]           rd_grant,
    output logic [NUM_FU*OP_W-1:0]      fu_op,
    output logic [NUM_FU-1:0]           wb_grant
);

    localparam int FU_W  = $clog2(NUM_FU);
    localparam int REG_W = $clog2(NUM_REGS);
    localparam int TAG_W = $clog2(NUM_FU + 1);

    logic [NUM_FU-1:0]              busy_w, wb_req_w, rdy1_w, rdy2_w, issue_en;
    logic [NUM_FU-1:0][REG_W-1:0]   dst_w, src1_w, src2_w;
    logic [NUM_FU-1:0][OP_W-1:0]    op_w;
    logic [NUM_REGS-1:0][TAG_W-1:0] tbl_w;
    logic [TAG_W-1:0]               q1_w, q2_w, set_tag_w;

    sb_issue_gate #(
        .NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS),
        .FU_W(FU_W), .REG_W(REG_W), .TAG_W(TAG_W)
    ) u_gate (
        .in_valid (in_valid),
        .in_fu    (in_fu),
        .in_dst   (in_dst),
        .in_src1  (in_src1),
        .in_src2  (in_src2),
        .busy     (busy_w),
        .wb_grant (wb_grant),
        .tbl      (tbl_w),
        .in_ready (in_ready),
        .issue_en (issue_en),
        .q1       (q1_w),
        .q2       (q2_w),
        .set_tag  (set_tag_w)
    );

    sb_result_table #(
        .NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS), .REG_W(REG_W), .TAG_W(TAG_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (|issue_en),
        .set_reg (in_dst),
        .set_tag (set_tag_w),
        .clr_en  (wb_grant),
        .clr_reg (dst_w),
        .tbl_o   (tbl_w)
    );

    generate
        for (genvar k = 0; k < NUM_FU; k++) begin : g_slot
            sb_fu_slot #(
                .NUM_FU(NUM_FU), .OP_W(OP_W), .REG_W(REG_W), .TAG_W(TAG_W)
            ) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .issue_en   (issue_en[k]),
                .iss_op     (in_op),
                .iss_dst    (in_dst),
                .iss_src1   (in_src1),
                .iss_src2   (in_src2),
                .iss_q1     (q1_w),
                .iss_q2     (q2_w),
                .wb_bcast   (wb_grant),
                .ex_done_i  (ex_done[k]),
                .wb_grant_i (wb_grant[k]),
                .busy_o     (busy_w[k]),
                .wb_req_o   (wb_req_w[k]),
                .rd_grant_o (rd_grant[k]),
                .op_o       (op_w[k]),
                .dst_o      (dst_w[k]),
                .src1_o     (src1_w[k]),
                .src2_o     (src2_w[k]),
                .rdy1_o     (rdy1_w[k]),
                .rdy2_o     (rdy2_w[k])
            );
            assign fu_op[k*OP_W +: OP_W] = op_w[k];

            // R8: write-back without a same-cycle reissue leaves the unit free
            p_wb_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (wb_grant[k] && !issue_en[k]) |=> !busy_w[k]);

            // R2: a busy unit is never issued to unless it retires now
            p_no_double_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
                issue_en[k] |-> (!busy_w[k] || wb_grant[k]));
        end
    endgenerate

    sb_hazard_net #(.NUM_FU(NUM_FU), .REG_W(REG_W)) u_hazard (
        .wb_req   (wb_req_w),
        .dst      (dst_w),
        .src1     (src1_w),
        .src2     (src2_w),
        .rdy1     (rdy1_w),
        .rdy2     (rdy2_w),
        .wb_grant (wb_grant)
    );

    // R1: at most one instruction enters per cycle
    p_issue_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_en));

endmodule

// File: tb/sb_scoreboard_bench.sv
module sb_scoreboard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NFU = 4;
    localparam int OPW = 4;
    localparam int NROWS = 25;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [1:0]     in_fu = '0;
    logic [OPW-1:0] in_op = '0;
    logic [2:0]     in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [NFU-1:0] ex_done = '0;
    logic [NFU-1:0] rd_grant, wb_grant;
    logic [NFU*OPW-1:0] fu_op;

    int checks = 0;
    int errors = 0;
    logic [OPW-1:0] exp_op [NFU];

    always #(CLK_PERIOD/2) clk = ~clk;

    sb_scoreboard u_sb_scoreboard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_fu(in_fu), .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1),
        .in_src2(in_src2), .ex_done(ex_done), .rd_grant(rd_grant),
        .fu_op(fu_op), .wb_grant(wb_grant)
    );

    typedef struct packed {
        logic       vld;
        logic [1:0] fu;
        logic [2:0] dst;
        logic [2:0] s1;
        logic [2:0] s2;
        logic [3:0] done;
        logic       rdy;
        logic [3:0] rd;
        logic [3:0] wb;
        logic [3:0] req;
    } row_t;

    // One row per cycle; inputs applied in that cycle, outputs expected in it
    localparam row_t VEC [NROWS] = '{
        '{1, 1, 1, 2, 3, 4'b0000, 1, 4'b0000, 4'b0000, 1},  // c0  A: mul r1=r2,r3
        '{1, 0, 4, 1, 5, 4'b0000, 1, 4'b0010, 4'b0000, 4},  // c1  A reads; B add r4=r1,r5
        '{1, 0, 6, 4, 7, 4'b0000, 0, 4'b0000, 4'b0000, 2},  // c2  C blocked: unit 0 busy
        '{1, 0, 6, 4, 7, 4'b0010, 0, 4'b0000, 4'b0000, 1},  // c3  C held; A done
        '{1, 0, 6, 4, 7, 4'b0000, 0, 4'b0000, 4'b0010, 7},  // c4  A writes back
        '{1, 0, 6, 4, 7, 4'b0000, 0, 4'b0001, 4'b0000, 9},  // c5  B released, reads
        '{1, 0, 6, 4, 7, 4'b0001, 0, 4'b0000, 4'b0000, 2},  // c6  B done
        '{1, 0, 6, 4, 7, 4'b0000, 1, 4'b0000, 4'b0001, 8},  // c7  B wb, C takes unit 0
        '{1, 1, 2, 6, 3, 4'b0000, 1, 4'b0001, 4'b0000, 9},  // c8  C reads; E mul r2=r6,r3
        '{1, 3, 3, 1, 1, 4'b0000, 1, 4'b0000, 4'b0000, 5},  // c9  F logic r3=r1,r1
        '{0, 2, 0, 0, 0, 4'b0000, 1, 4'b1000, 4'b0000, 4},  // c10 F reads
        '{0, 2, 0, 0, 0, 4'b1000, 1, 4'b0000, 4'b0000, 7},  // c11 F done
        '{1, 2, 3, 5, 5, 4'b0000, 0, 4'b0000, 4'b0000, 3},  // c12 F held by E; G waw stall
        '{1, 2, 3, 5, 5, 4'b0001, 0, 4'b0000, 4'b0000, 5},  // c13 C done
        '{1, 2, 3, 5, 5, 4'b0000, 0, 4'b0000, 4'b0001, 5},  // c14 C wb, F still held
        '{1, 2, 3, 5, 5, 4'b0000, 0, 4'b0010, 4'b0000, 9},  // c15 E released, reads
        '{1, 2, 3, 5, 5, 4'b0000, 1, 4'b0000, 4'b1000, 6},  // c16 F wb, G issues on r3
        '{1, 3, 3, 0, 0, 4'b0000, 0, 4'b0100, 4'b0000, 8},  // c17 G reads; H waw on G
        '{0, 3, 0, 0, 0, 4'b0010, 1, 4'b0000, 4'b0000, 7},  // c18 E done
        '{0, 3, 0, 0, 0, 4'b0100, 1, 4'b0000, 4'b0010, 7},  // c19 E wb; G done
        '{0, 3, 0, 0, 0, 4'b0000, 1, 4'b0000, 4'b0100, 7},  // c20 G wb
        '{1, 3, 3, 0, 0, 4'b0000, 1, 4'b0000, 4'b0000, 8},  // c21 H issues
        '{0, 0, 0, 0, 0, 4'b0000, 1, 4'b1000, 4'b0000, 4},  // c22 H reads
        '{0, 0, 0, 0, 0, 4'b1000, 1, 4'b0000, 4'b0000, 7},  // c23 H done
        '{0, 0, 0, 0, 0, 4'b0000, 1, 4'b0000, 4'b1000, 7}   // c24 H wb
    };

    function automatic string tag_name(input int r);
        case (r)
            1:  return "R1";
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] fu, input logic [2:0] d,
                         input logic [2:0] a, input logic [2:0] b,
                         input logic [3:0] done, input logic [OPW-1:0] op);
        in_valid = v; in_fu = fu; in_dst = d; in_src1 = a; in_src2 = b;
        ex_done = done; in_op = op;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < NFU; k++) exp_op[k] = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R10", "in_ready in reset", {15'd0, in_ready}, 16'd1);
        check("R10", "rd_grant in reset", {12'd0, rd_grant}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10", "wb_grant after reset", {12'd0, wb_grant}, 16'd0);

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            drive(VEC[i].vld, VEC[i].fu, VEC[i].dst, VEC[i].s1, VEC[i].s2,
                  VEC[i].done, OPW'(i));
            #1;
            check(tag_name(int'(VEC[i].req)), $sformatf("in_ready c%0d", i),
                  {15'd0, in_ready}, {15'd0, VEC[i].rdy});
            check(tag_name(int'(VEC[i].req)), $sformatf("rd_grant c%0d", i),
                  {12'd0, rd_grant}, {12'd0, VEC[i].rd});
            check(tag_name(int'(VEC[i].req)), $sformatf("wb_grant c%0d", i),
                  {12'd0, wb_grant}, {12'd0, VEC[i].wb});
            for (int k = 0; k < NFU; k++) begin
                if (VEC[i].rd[k])
                    check("R11", $sformatf("fu_op unit %0d c%0d", k, i),
                          {12'd0, fu_op[k*OPW +: OPW]}, {12'd0, exp_op[k]});
            end
            if (VEC[i].vld && VEC[i].rdy) exp_op[VEC[i].fu] = OPW'(i);
        end

        // Completion pulse on an idle unit is ignored (R7)
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 4'b0001, 0);
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 4'b0000, 0);
        #1;
        check("R7", "wb_grant after idle done", {12'd0, wb_grant}, 16'd0);
        check("R7", "in_ready after idle done", {15'd0, in_ready}, 16'd1);

        // Issue to unit 0, read pulse width, no write-back without completion
        @(negedge clk);
        drive(1, 0, 5, 0, 0, 4'b0000, 4'hA);
        #1;
        check("R1", "in_ready directed issue", {15'd0, in_ready}, 16'd1);
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 4'b0000, 0);
        #1;
        check("R4", "rd_grant cycle after issue", {12'd0, rd_grant}, 16'd1);
        check("R11", "fu_op unit 0", {12'd0, fu_op[OPW-1:0]}, 16'hA);
        @(negedge clk);
        #1;
        check("R6", "rd_grant lasts one cycle", {12'd0, rd_grant}, 16'd0);
        @(negedge clk);
        drive(1, 1, 5, 0, 0, 4'b0000, 0);
        #1;
        check("R3", "waw stall on r5", {15'd0, in_ready}, 16'd0);
        check("R7", "no wb without done", {12'd0, wb_grant}, 16'd0);

        // Reset in flight clears every record and the table (R10)
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R10", "rd_grant under reset", {12'd0, rd_grant}, 16'd0);
        rst_n = 1'b1;
        drive(1, 0, 5, 0, 0, 4'b0000, 0);
        #1;
        check("R10", "in_ready after mid reset", {15'd0, in_ready}, 16'd1);
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 4'b0000, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule